// File: doc/BRIEF.md
# IDE PIO Register Access Engine

This block converts one host-side register request at a time into the strobe sequence of an 8-bit parallel ATA (IDE) port. The host supplies a 3-bit register index, a direction flag, a write byte and a one-cycle start pulse. The block then runs the drive-side handshake and signals completion with a one-cycle done pulse. For a read, the byte it captured from the drive appears on the read-data output at that pulse.

On the drive side the block drives the address lines A0..A2 and the active-low chip select 0, read strobe, write strobe and drive reset. The data bus is split into an output byte, an input byte and an output-enable that the pad ring combines into one bidirectional bus. Every phase of the handshake lasts a parameterised number of clock cycles, so the minimum PIO timing can be met at any clock rate.

The register index uses the usual task-file layout: 0 data, 1 error/features, 2 sector count, 3 LBA[7:0], 4 LBA[15:8], 5 LBA[23:16], 6 head/device, 7 status on read and command on write. The engine passes the index through and does not interpret it.

Top module: `ide_pio_engine`

## Requirements
- R1: The drive reset output `ide_rst_no` is 1 at every cycle after reset, including during every access.
- R2: While idle, `ide_cs0_no`, `ide_rd_no` and `ide_wr_no` are 1, `ide_d_oe_o` is 0, and `busy_o` and `done_o` are 0.
- R3: A write that is accepted at clock edge E runs through four phases, counting the cycles after E. For SETUP_CYC cycles, chip select is low, both strobes are high and the output-enable is 0. For the next SETUP_CYC cycles, the output-enable is 1 and `ide_d_o` carries the write byte. For the next STROBE_CYC cycles, `ide_wr_no` is low. For the next HOLD_CYC cycles, `ide_wr_no` is high again while chip select stays low and the bus is still driven. In the following cycle, chip select rises and the output-enable falls together.
- R4: While chip select is low, `ide_a_o` equals the register index that was latched when the request was accepted (0 data through 7 status/command). Changes on `addr_i` during the access do not affect it.
- R5: A read keeps the output-enable at 0 throughout. Chip select is low for SETUP_CYC cycles with both strobes high. `ide_rd_no` is then low for STROBE_CYC cycles, and `ide_d_i` is sampled in the last of those cycles. `ide_rd_no` is then high for HOLD_CYC cycles before chip select rises.
- R6: `rdata_o` shows the byte sampled by the latest read from its done pulse onward and holds that value until the next read completes.
- R7: `done_o` is a one-cycle pulse in the first cycle with chip select high again. `busy_o` is 1 from the cycle after acceptance up to and excluding that cycle. The done pulse comes 2*SETUP_CYC+STROBE_CYC+HOLD_CYC+1 cycles after acceptance for a write and SETUP_CYC+STROBE_CYC+HOLD_CYC+1 cycles after acceptance for a read.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: it starts no access and causes no write strobe, and the running access keeps its timing.
- R9: The read and write strobes are never low together, and neither strobe is ever low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only when idle |
| we_i | input | 1 | 1 = register write, 0 = register read |
| addr_i | input | 3 | Task-file register index |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte captured by the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |
| ide_d_i | input | 8 | Data bus from the drive |
| ide_d_o | output | 8 | Data bus to the drive |
| ide_d_oe_o | output | 1 | Data bus output-enable |
| ide_a_o | output | 3 | Register address lines A0..A2 |
| ide_cs0_no | output | 1 | Chip select 0, active low |
| ide_rd_no | output | 1 | Read strobe, active low |
| ide_wr_no | output | 1 | Write strobe, active low |
| ide_rst_no | output | 1 | Drive reset, active low |

## Verification
The assertions check the pin relations on every cycle:
- the two strobes are never low together, and neither is low without chip select;
- the data is enabled before the write strobe falls;
- the bus is released in the same cycle as chip select;
- no strobe is active in the cycle before chip select rises;
- a read never drives the bus;
- a start pulse during an access leaves the latched request untouched.

Only the bench's scenarios can show the exact phase lengths, the completion latency, the byte values that reach the drive model and come back, and the rule that a start pulse during an access adds no second write. The bench compares every cycle of every write and read over all eight register indices against waveforms it computes from the phase parameters.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DRIVE,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  localparam logic [2:0] REG_DATA    = 3'd0;
  localparam logic [2:0] REG_ERRFEAT = 3'd1;
  localparam logic [2:0] REG_COUNT   = 3'd2;
  localparam logic [2:0] REG_LBA_LO  = 3'd3;
  localparam logic [2:0] REG_LBA_MID = 3'd4;
  localparam logic [2:0] REG_LBA_HI  = 3'd5;
  localparam logic [2:0] REG_DEVHEAD = 3'd6;
  localparam logic [2:0] REG_STATCMD = 3'd7;
endpackage

// File: rtl/ide_phase_timer.sv
module ide_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || last_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int CNT_W      = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output phase_e     phase_o,
  output logic       we_o,
  output logic [2:0] addr_o,
  output logic [7:0] wdata_o,
  output logic       sample_o,
  output logic       done_o,
  output logic       busy_o
);
  phase_e           phase_q, phase_d;
  logic             we_q;
  logic [2:0]       addr_q;
  logic [7:0]       wdata_q;
  logic             done_q;
  logic             last;
  logic [CNT_W-1:0] len;
  logic             accept;

  assign accept = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    unique case (phase_q)
      PH_STROBE: len = CNT_W'(STROBE_CYC);
      PH_HOLD:   len = CNT_W'(HOLD_CYC);
      default:   len = CNT_W'(SETUP_CYC);
    endcase
  end

  ide_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_q != PH_IDLE),
    .len_i  (len),
    .last_o (last)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start_i) phase_d = PH_ADDR;
      PH_ADDR:   if (last)    phase_d = we_q ? PH_DRIVE : PH_STROBE;
      PH_DRIVE:  if (last)    phase_d = PH_STROBE;
      PH_STROBE: if (last)    phase_d = PH_HOLD;
      PH_HOLD:   if (last)    phase_d = PH_IDLE;
      default:                phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_HOLD) && last;
      if (accept) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign phase_o  = phase_q;
  assign we_o     = we_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign sample_o = (phase_q == PH_STROBE) && last && !we_q;
  assign done_o   = done_q;
  assign busy_o   = phase_q != PH_IDLE;

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(addr_q) && $stable(we_q) && $stable(wdata_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: rtl/ide_pio_pins.sv
module ide_pio_pins
  import ide_pio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  phase_e     phase_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       sample_i,
  input  logic [7:0] ide_d_i,
  output logic [7:0] rdata_o,
  output logic [7:0] ide_d_o,
  output logic       ide_d_oe_o,
  output logic [2:0] ide_a_o,
  output logic       ide_cs0_no,
  output logic       ide_rd_no,
  output logic       ide_wr_no,
  output logic       ide_rst_no
);
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (sample_i) rdata_q <= ide_d_i;
  end

  assign rdata_o    = rdata_q;
  assign ide_a_o    = addr_i;
  assign ide_d_o    = wdata_i;
  assign ide_cs0_no = (phase_i == PH_IDLE);
  assign ide_rd_no  = !((phase_i == PH_STROBE) && !we_i);
  assign ide_wr_no  = !((phase_i == PH_STROBE) && we_i);
  // bus stays driven through the hold phase, released with chip select
  assign ide_d_oe_o = we_i && (phase_i inside {PH_DRIVE, PH_STROBE, PH_HOLD});
  assign ide_rst_no = 1'b1;

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_rd_no || ide_wr_no);

  // R9
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ide_rd_no || !ide_wr_no) |-> !ide_cs0_no);

  // R3
  data_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ide_wr_no) |-> $past(ide_d_oe_o));

  // R3
  wr_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ide_wr_no |-> ide_d_oe_o);

  // R3
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ide_cs0_no) |-> !ide_d_oe_o && $past(ide_wr_no && ide_rd_no));

  // R5
  read_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ide_rd_no |-> !ide_d_oe_o);

  // R2
  idle_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_cs0_no |-> !ide_d_oe_o);
endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       done_o,
  output logic       busy_o,
  input  logic [7:0] ide_d_i,
  output logic [7:0] ide_d_o,
  output logic       ide_d_oe_o,
  output logic [2:0] ide_a_o,
  output logic       ide_cs0_no,
  output logic       ide_rd_no,
  output logic       ide_wr_no,
  output logic       ide_rst_no
);
  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_e     phase;
  logic       we_q;
  logic [2:0] addr_q;
  logic [7:0] wdata_q;
  logic       sample;

  initial begin
    if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1)
      $error("phase lengths must be at least one cycle");
  end

  ide_pio_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CNT_W      (CNT_W)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .phase_o  (phase),
    .we_o     (we_q),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .sample_o (sample),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  ide_pio_pins i_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .we_i       (we_q),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .sample_i   (sample),
    .ide_d_i    (ide_d_i),
    .rdata_o    (rdata_o),
    .ide_d_o    (ide_d_o),
    .ide_d_oe_o (ide_d_oe_o),
    .ide_a_o    (ide_a_o),
    .ide_cs0_no (ide_cs0_no),
    .ide_rd_no  (ide_rd_no),
    .ide_wr_no  (ide_wr_no),
    .ide_rst_no (ide_rst_no)
  );
endmodule

// File: tb/test_ide_pio_engine.sv
module test_ide_pio_engine;
  localparam int S  = 2;
  localparam int T  = 3;
  localparam int H  = 2;
  localparam int LW = 2*S + T + H;
  localparam int LR = S + T + H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       done, busy;
  logic [7:0] d_i, d_o;
  logic       oe;
  logic [2:0] a;
  logic       cs_n, rd_n, wr_n, rst_o_n;

  int n_chk = 0;
  int n_fail = 0;
  int viol_rst = 0;
  int viol_strb = 0;
  logic [7:0] drv_regs [8];
  logic [7:0] exp_regs [8];
  logic       wr_pend = 1'b0;
  logic [7:0] wr_lat_d;
  logic [2:0] wr_lat_a;
  bit         finished = 0;

  always #10 clk = ~clk;

  ide_pio_engine #(.SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H)) i_ide_pio_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .ide_d_i(d_i), .ide_d_o(d_o), .ide_d_oe_o(oe), .ide_a_o(a),
    .ide_cs0_no(cs_n), .ide_rd_no(rd_n), .ide_wr_no(wr_n), .ide_rst_no(rst_o_n)
  );

  // drive model: returns register contents only while selected and read-strobed
  assign d_i = (!cs_n && !rd_n) ? drv_regs[a] : 8'hA5;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_o_n !== 1'b1) viol_rst++;
      if ((!rd_n && !wr_n) || ((!rd_n || !wr_n) && cs_n)) viol_strb++;
      if (!wr_n) begin
        wr_pend  <= 1'b1;
        wr_lat_d <= d_o;
        wr_lat_a <= a;
      end else if (wr_pend) begin
        drv_regs[wr_lat_a] <= wr_lat_d;
        wr_pend <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one access; inj: pulse start with a different request mid-access
  task automatic xfer(input bit w, input logic [2:0] ad, input logic [7:0] wd,
                      input bit inj, input string req);
    int len = w ? LW : LR;
    int err_pin = 0, err_addr = 0, done_at = -1, dones = 0;
    @(negedge clk);
    start = 1'b1; we = w; addr = ad; wdata = wd;
    for (int i = 1; i <= len + 1; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (inj && i == 3) begin
        start = 1'b1; we = 1'b1; addr = ad ^ 3'd6; wdata = ~wd;
      end
      if (inj && i == 4) start = 1'b0;
      begin
        bit e_cs, e_rd, e_wr, e_oe, e_busy, e_done;
        e_cs   = !(i <= len);
        e_busy = (i <= len);
        e_done = (i == len + 1);
        if (w) begin
          e_wr = !(i > 2*S && i <= 2*S + T);
          e_rd = 1'b1;
          e_oe = (i > S && i <= len);
        end else begin
          e_wr = 1'b1;
          e_rd = !(i > S && i <= S + T);
          e_oe = 1'b0;
        end
        if (cs_n !== e_cs || rd_n !== e_rd || wr_n !== e_wr || oe !== e_oe ||
            busy !== e_busy || (e_oe && d_o !== wd)) err_pin++;
        if (!cs_n && a !== ad) err_addr++;
        if (done) begin dones++; if (done_at < 0) done_at = i; end
      end
    end
    chk(err_pin == 0, w ? "R3 write phases" : "R5 read phases", err_pin, 0);
    chk(err_addr == 0, "R4 address held", err_addr, 0);
    chk(done_at == len + 1 && dones == 1, "R7 done latency", done_at, len + 1);
    if (w) exp_regs[ad] = wd;
    else chk(rdata == exp_regs[ad], "R6 read data", rdata, exp_regs[ad]);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin drv_regs[k] = 8'h00; exp_regs[k] = 8'h00; end
    repeat (3) @(negedge clk);
    // R2 reset and idle state
    chk(cs_n && rd_n && wr_n && !oe && !busy && !done, "R2 reset idle",
        {cs_n, rd_n, wr_n, oe, busy, done}, 6'b111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && rd_n && wr_n && !oe && !busy && !done, "R2 idle after reset",
        {cs_n, rd_n, wr_n, oe, busy, done}, 6'b111000);

    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 8; k++)
        xfer(1'b1, 3'(k), 8'((k * 37 + 5) ^ (p ? 8'hFF : 8'h5A)), 1'b0, "R3");
      for (int k = 7; k >= 0; k--)
        xfer(1'b0, 3'(k), 8'h00, 1'b0, "R5");
    end

    // R6 read data holds while idle and across a write
    begin
      logic [7:0] held;
      held = rdata;
      repeat (5) @(negedge clk);
      chk(rdata == held, "R6 hold while idle", rdata, held);
      xfer(1'b1, 3'd2, 8'h3C, 1'b0, "R3");
      chk(rdata == held, "R6 hold across write", rdata, held);
    end

    // R8 start during busy ignored: target of injected request is 3^6=5
    xfer(1'b1, 3'd3, 8'h96, 1'b1, "R8");
    repeat (3) @(negedge clk);
    chk(!busy && cs_n, "R8 no second access", {busy, cs_n}, 2'b01);
    xfer(1'b0, 3'd5, 8'h00, 1'b0, "R8");
    chk(rdata == exp_regs[5], "R8 injected write absent", rdata, exp_regs[5]);
    xfer(1'b0, 3'd3, 8'h00, 1'b0, "R8");
    chk(rdata == 8'h96, "R8 original write landed", rdata, 8'h96);
    // read injection: request a read, inject a write start
    xfer(1'b0, 3'd1, 8'h00, 1'b1, "R8");
    xfer(1'b0, 3'd7, 8'h00, 1'b0, "R8");
    chk(rdata == exp_regs[7], "R8 read injection no write", rdata, exp_regs[7]);

    chk(viol_rst == 0, "R1 reset line high", viol_rst, 0);
    chk(viol_strb == 0, "R9 strobe exclusivity", viol_strb, 0);
    summary();
  end
endmodule